// File: doc/BRIEF.md
# Address Translation Sequencer

This block steers one effective-to-real address translation at a time through a fixed chain of decisions and turns whichever step fails into a fault report. A request carries the effective address, the access kind (load, store or instruction fetch), the privilege level, a real-mode flag and the answer of an external block matcher. The sixteen segment registers arrive as a flat bus. When the access needs a page-table lookup, the sequencer hands the virtual segment ID and page index to an external table walker and waits for its answer.

The steps are tried in this order: real mode, block match, segment selection, direct-store segment, segment no-execute, table walk, then page protection. A successful translation returns a real address and a permission triple {execute, write, read}. A failed one returns a fault flag. Fetch faults carry a 32-bit instruction-fault code. Data faults carry a 32-bit data-fault status word and the faulting effective address. The status word depends on the cause and on whether the access was a store.

Requests use a valid/ready handshake. `req_ready` is high only while no translation is in flight. A response stays on `rsp_valid` with every result field frozen until `rsp_ready` is sampled high. The result registers then keep their values until the next response is produced. The walker side is a plain request/answer pair: `walk_req_valid` stays high until the walker raises `walk_rsp_valid` for one cycle.

Top module: `xlt_seq`

## Requirements
- R1: `req_ready` is high exactly when no translation is in flight. A request accepted on a rising edge makes `rsp_valid` rise either one edge later or on the edge that samples `walk_rsp_valid`. While `rsp_valid` is high and `rsp_ready` is low, all response fields stay unchanged. After the edge that samples `rsp_ready` high, `req_ready` is high again.
- R2: With `req_real` high the response is no fault, `rsp_raddr` equal to the effective address, and `rsp_perm` = 3'b111. The block-match inputs and segment registers have no effect in this case, and no walk is requested.
- R3: Outside real mode, `bm_hit` takes precedence over the segment registers, and no walk is requested. Block permission is decoded from `bm_pp`: 0 gives none, 2 gives 3'b111, and 1 or 3 gives read+execute (3'b101). On success `rsp_raddr` = `bm_raddr`.
- R4: If the access is not allowed by the block permission, the response is a protection fault. Fetch, load and store are distinguished by `req_acc` = 2'b10, 2'b00 and 2'b01; 2'b11 behaves as a load. A fetch needs execute, a store needs write and a load needs read. The codes are instruction code 0x08000000 for a fetch, and status 0x0A000000 for a store or 0x08000000 for a load.
- R5: The segment register is picked by effective-address bits 31:28, where register n sits at `seg_regs[32n+31:32n]`. A walk is requested only when no earlier step has decided the result. During the walk `walk_vsid` is segment bits 23:0 and `walk_page` is effective-address bits 27:12.
- R6: If segment bit 31 (direct store) is set, the access is not walked. A fetch faults with instruction code 0x10000000. A data access gets permission 3'b001 when the effective key is 0 and 3'b011 when it is 1, with `rsp_raddr` equal to the effective address. A store with key 0 faults with status 0x0A000000.
- R7: If segment bit 28 (no-execute) is set, a fetch faults with instruction code 0x10000000 and no walk is requested. A load or store to such a segment still proceeds to the walk.
- R8: The effective key is segment bit 29 when `req_user` is high and segment bit 30 when it is low.
- R9: If the walker answers with `walk_hit` low, the response is a miss fault. The codes are instruction code 0x40000000 for a fetch, and status 0x42000000 for a store or 0x40000000 for a load.
- R10: On a walk hit, page permission comes from the key and `walk_pp`. With key 0, codes 0 to 2 give 3'b111 and code 3 gives 3'b101. With key 1, code 0 gives none, code 2 gives 3'b111, and codes 1 and 3 give 3'b101. On success `rsp_raddr` is {`walk_rpn`, effective-address bits 11:0}.
- R11: A walk hit whose page permission does not allow the access gives a protection fault. It uses the same codes as R4: 0x08000000 for a fetch, 0x0A000000 for a store and 0x08000000 for a load.
- R12: On a fault, `rsp_raddr` and `rsp_perm` are zero. A fetch fault leaves `rsp_dsisr` and `rsp_dar` zero. A data fault sets `rsp_dar` to the effective address and leaves `rsp_ins_code` zero. A success leaves all three fault fields zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_ea | input | 32 | Effective address |
| req_acc | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 as load |
| req_user | input | 1 | User privilege (selects the user key) |
| req_real | input | 1 | Translation off |
| seg_regs | input | 512 | Sixteen 32-bit segment registers, register n at bits 32n+31:32n |
| bm_hit | input | 1 | Block matcher hit for this request |
| bm_pp | input | 2 | Block protection code |
| bm_raddr | input | 32 | Real address formed by the block matcher |
| walk_req_valid | output | 1 | Walk requested, high until answered |
| walk_vsid | output | 24 | Virtual segment ID for the walk |
| walk_page | output | 16 | Page index for the walk |
| walk_rsp_valid | input | 1 | One-cycle walker answer |
| walk_hit | input | 1 | Matching entry found |
| walk_pp | input | 2 | Page protection code of the entry |
| walk_rpn | input | 20 | Real page number of the entry |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_fault | output | 1 | Translation failed |
| rsp_raddr | output | 32 | Real address |
| rsp_perm | output | 3 | Permission {execute, write, read} |
| rsp_ins_code | output | 32 | Instruction-fault code |
| rsp_dsisr | output | 32 | Data-fault status word |
| rsp_dar | output | 32 | Faulting effective address for data faults |

## Verification
Directed requests place one stage at a time on the deciding path. Real mode is tried with a block hit present, and a block hit with a direct-store segment behind it, which shows that priority is applied and not merely that each stage works. Each fault cause is issued as fetch, load and store to separate the store flag from the cause field. The same segment is used under both privileges to show which key bit is read. Random requests then vary segment bits, protection codes, walker latency and response back-pressure. They compare the walker fields, the path taken and the frozen response against a bench model.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_NOEXEC = 2'd1,
    CAUSE_MISS   = 2'd2,
    CAUSE_PROT   = 2'd3
  } cause_e;

  localparam logic [1:0] ACC_LOAD  = 2'b00;
  localparam logic [1:0] ACC_STORE = 2'b01;
  localparam logic [1:0] ACC_FETCH = 2'b10;

  localparam logic [31:0] CODE_NOEXEC = 32'h1000_0000;
  localparam logic [31:0] CODE_MISS   = 32'h4000_0000;
  localparam logic [31:0] CODE_PROT   = 32'h0800_0000;
  localparam logic [31:0] FLAG_STORE  = 32'h0200_0000;

  // permission triple {x, w, r}
  localparam logic [2:0] PERM_NONE = 3'b000;
  localparam logic [2:0] PERM_R    = 3'b001;
  localparam logic [2:0] PERM_RW   = 3'b011;
  localparam logic [2:0] PERM_RX   = 3'b101;
  localparam logic [2:0] PERM_RWX  = 3'b111;

  function automatic logic perm_allows(input logic [2:0] perm, input logic [1:0] acc);
    case (acc)
      ACC_FETCH: perm_allows = perm[2];
      ACC_STORE: perm_allows = perm[1];
      default:   perm_allows = perm[0];
    endcase
  endfunction

endpackage

// File: rtl/xlt_seg_sel.sv
module xlt_seg_sel #(
  parameter int unsigned SEG_IDX_W = 4,
  parameter int unsigned SR_W      = 32,
  parameter int unsigned VSID_W    = 24
) (
  input  logic [(1<<SEG_IDX_W)*SR_W-1:0] seg_regs,
  input  logic [SEG_IDX_W-1:0]           seg_idx,
  input  logic                           user,
  output logic                           ds,
  output logic                           nx,
  output logic                           key,
  output logic [VSID_W-1:0]              vsid
);
  localparam int unsigned NSEG   = 1 << SEG_IDX_W;
  localparam int unsigned B_DS   = SR_W - 1;
  localparam int unsigned B_KS   = SR_W - 2;
  localparam int unsigned B_KU   = SR_W - 3;
  localparam int unsigned B_NX   = SR_W - 4;

  logic [SR_W-1:0] sr_tab [NSEG];
  logic [SR_W-1:0] sr;

  for (genvar g = 0; g < NSEG; g++) begin : g_unpack
    assign sr_tab[g] = seg_regs[g*SR_W +: SR_W];
  end

  assign sr   = sr_tab[seg_idx];
  assign ds   = sr[B_DS];
  assign nx   = sr[B_NX];
  assign key  = user ? sr[B_KU] : sr[B_KS];
  assign vsid = sr[VSID_W-1:0];

  // bits between the flags and the segment ID carry no meaning here
  logic unused_gap;
  assign unused_gap = ^sr[B_NX-1:VSID_W];

endmodule

// File: rtl/xlt_page_prot.sv
module xlt_page_prot
  import xlt_pkg::*;
(
  input  logic       key,
  input  logic [1:0] pp,
  output logic [2:0] perm
);
  always_comb begin
    if (!key) begin
      perm = (pp == 2'd3) ? PERM_RX : PERM_RWX;
    end else begin
      case (pp)
        2'd0:    perm = PERM_NONE;
        2'd2:    perm = PERM_RWX;
        default: perm = PERM_RX;
      endcase
    end
  end
endmodule

// File: rtl/xlt_fault_enc.sv
module xlt_fault_enc
  import xlt_pkg::*;
#(
  parameter int unsigned EA_W = 32
) (
  input  cause_e          cause,
  input  logic [1:0]      acc,
  input  logic [EA_W-1:0] ea,
  output logic            fault,
  output logic [31:0]     ins_code,
  output logic [31:0]     dsisr,
  output logic [EA_W-1:0] dar
);
  logic [31:0] base;
  logic        is_fetch;

  assign is_fetch = (acc == ACC_FETCH);
  assign fault    = (cause != CAUSE_NONE);

  always_comb begin
    case (cause)
      CAUSE_NOEXEC: base = CODE_NOEXEC;
      CAUSE_MISS:   base = CODE_MISS;
      CAUSE_PROT:   base = CODE_PROT;
      default:      base = '0;
    endcase
  end

  always_comb begin
    ins_code = '0;
    dsisr    = '0;
    dar      = '0;
    if (fault) begin
      if (is_fetch) begin
        ins_code = base;
      end else begin
        dsisr = (cause == CAUSE_NOEXEC) ? '0
              : (base | ((acc == ACC_STORE) ? FLAG_STORE : 32'h0));
        dar   = ea;
      end
    end
  end
endmodule

// File: rtl/xlt_seq.sv
module xlt_seq
  import xlt_pkg::*;
#(
  parameter int unsigned EA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned SEG_IDX_W = 4,
  parameter int unsigned SR_W      = 32,
  parameter int unsigned VSID_W    = 24
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic [EA_W-1:0]                 req_ea,
  input  logic [1:0]                      req_acc,
  input  logic                            req_user,
  input  logic                            req_real,
  input  logic [(1<<SEG_IDX_W)*SR_W-1:0]  seg_regs,
  input  logic                            bm_hit,
  input  logic [1:0]                      bm_pp,
  input  logic [EA_W-1:0]                 bm_raddr,
  output logic                            walk_req_valid,
  output logic [VSID_W-1:0]               walk_vsid,
  output logic [EA_W-SEG_IDX_W-PAGE_BITS-1:0] walk_page,
  input  logic                            walk_rsp_valid,
  input  logic                            walk_hit,
  input  logic [1:0]                      walk_pp,
  input  logic [EA_W-PAGE_BITS-1:0]       walk_rpn,
  output logic                            rsp_valid,
  input  logic                            rsp_ready,
  output logic                            rsp_fault,
  output logic [EA_W-1:0]                 rsp_raddr,
  output logic [2:0]                      rsp_perm,
  output logic [31:0]                     rsp_ins_code,
  output logic [31:0]                     rsp_dsisr,
  output logic [EA_W-1:0]                 rsp_dar
);
  localparam int unsigned SEG_LSB = EA_W - SEG_IDX_W;
  localparam int unsigned PIDX_W  = SEG_LSB - PAGE_BITS;

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_DONE} state_e;
  state_e state;

  logic req_fire;
  assign req_ready = (state == ST_IDLE);
  assign req_fire  = req_valid && req_ready;

  // ---------------- segment selection ----------------
  logic              seg_ds, seg_nx, seg_key;
  logic [VSID_W-1:0] seg_vsid;

  xlt_seg_sel #(.SEG_IDX_W(SEG_IDX_W), .SR_W(SR_W), .VSID_W(VSID_W)) u_seg (
    .seg_regs (seg_regs),
    .seg_idx  (req_ea[EA_W-1:SEG_LSB]),
    .user     (req_user),
    .ds       (seg_ds),
    .nx       (seg_nx),
    .key      (seg_key),
    .vsid     (seg_vsid)
  );

  // ---------------- steps decided at acceptance ----------------
  logic            fast_walk;
  cause_e          fast_cause;
  logic [EA_W-1:0] fast_raddr;
  logic [2:0]      fast_perm;
  logic [2:0]      blk_perm;
  logic [2:0]      ds_perm;

  always_comb begin
    case (bm_pp)
      2'd0:    blk_perm = PERM_NONE;
      2'd2:    blk_perm = PERM_RWX;
      default: blk_perm = PERM_RX;
    endcase
    ds_perm = seg_key ? PERM_RW : PERM_R;
  end

  always_comb begin
    fast_walk  = 1'b0;
    fast_cause = CAUSE_NONE;
    fast_raddr = req_ea;
    fast_perm  = PERM_NONE;
    if (req_real) begin
      fast_perm = PERM_RWX;
    end else if (bm_hit) begin
      fast_raddr = bm_raddr;
      fast_perm  = blk_perm;
      if (!perm_allows(blk_perm, req_acc)) fast_cause = CAUSE_PROT;
    end else if (seg_ds) begin
      if (req_acc == ACC_FETCH) begin
        fast_cause = CAUSE_NOEXEC;
      end else begin
        fast_perm = ds_perm;
        if (!perm_allows(ds_perm, req_acc)) fast_cause = CAUSE_PROT;
      end
    end else if (seg_nx && (req_acc == ACC_FETCH)) begin
      fast_cause = CAUSE_NOEXEC;
    end else begin
      fast_walk = 1'b1;
    end
  end

  // ---------------- context held across the walk ----------------
  logic [EA_W-1:0]   ea_q;
  logic [1:0]        acc_q;
  logic              key_q;
  logic [VSID_W-1:0] vsid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q   <= '0;
      acc_q  <= ACC_LOAD;
      key_q  <= 1'b0;
      vsid_q <= '0;
    end else if (req_fire) begin
      ea_q   <= req_ea;
      acc_q  <= req_acc;
      key_q  <= seg_key;
      vsid_q <= seg_vsid;
    end
  end

  assign walk_req_valid = (state == ST_WALK);
  assign walk_vsid      = vsid_q;
  assign walk_page      = ea_q[SEG_LSB-1:PAGE_BITS];

  // ---------------- steps decided by the walk ----------------
  logic [2:0]      page_perm;
  cause_e          walk_cause;
  logic [EA_W-1:0] walk_raddr;

  xlt_page_prot u_pprot (
    .key  (key_q),
    .pp   (walk_pp),
    .perm (page_perm)
  );

  always_comb begin
    if (!walk_hit)                          walk_cause = CAUSE_MISS;
    else if (!perm_allows(page_perm, acc_q)) walk_cause = CAUSE_PROT;
    else                                     walk_cause = CAUSE_NONE;
  end
  assign walk_raddr = {walk_rpn, ea_q[PAGE_BITS-1:0]};

  // ---------------- shared fault encoding ----------------
  logic            in_walk;
  cause_e          sel_cause;
  logic [1:0]      sel_acc;
  logic [EA_W-1:0] sel_ea;
  logic [EA_W-1:0] sel_raddr;
  logic [2:0]      sel_perm;
  logic            enc_fault;
  logic [31:0]     enc_ins, enc_dsisr;
  logic [EA_W-1:0] enc_dar;

  assign in_walk   = (state == ST_WALK);
  assign sel_cause = in_walk ? walk_cause : fast_cause;
  assign sel_acc   = in_walk ? acc_q      : req_acc;
  assign sel_ea    = in_walk ? ea_q       : req_ea;
  assign sel_raddr = in_walk ? walk_raddr : fast_raddr;
  assign sel_perm  = in_walk ? page_perm  : fast_perm;

  xlt_fault_enc #(.EA_W(EA_W)) u_fenc (
    .cause    (sel_cause),
    .acc      (sel_acc),
    .ea       (sel_ea),
    .fault    (enc_fault),
    .ins_code (enc_ins),
    .dsisr    (enc_dsisr),
    .dar      (enc_dar)
  );

  logic finish;
  assign finish = (req_fire && !fast_walk) || (in_walk && walk_rsp_valid);

  // ---------------- sequencing ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (req_fire) state <= fast_walk ? ST_WALK : ST_DONE;
        ST_WALK: if (walk_rsp_valid) state <= ST_DONE;
        ST_DONE: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_fault    <= 1'b0;
      rsp_raddr    <= '0;
      rsp_perm     <= PERM_NONE;
      rsp_ins_code <= '0;
      rsp_dsisr    <= '0;
      rsp_dar      <= '0;
    end else if (finish) begin
      rsp_fault    <= enc_fault;
      rsp_raddr    <= enc_fault ? '0 : sel_raddr;
      rsp_perm     <= enc_fault ? PERM_NONE : sel_perm;
      rsp_ins_code <= enc_ins;
      rsp_dsisr    <= enc_dsisr;
      rsp_dar      <= enc_dar;
    end
  end

endmodule

// File: rtl/xlt_seq_chk.sv
module xlt_seq_chk #(
  parameter int unsigned EA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [EA_W-1:0] req_ea,
  input logic [1:0]      req_acc,
  input logic            req_real,
  input logic            walk_req_valid,
  input logic            walk_rsp_valid,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            rsp_fault,
  input logic [EA_W-1:0] rsp_raddr,
  input logic [2:0]      rsp_perm,
  input logic [31:0]     rsp_ins_code,
  input logic [31:0]     rsp_dsisr,
  input logic [EA_W-1:0] rsp_dar
);
  logic [EA_W-1:0] cap_ea;
  logic            cap_real;
  logic            cap_fetch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_ea    <= '0;
      cap_real  <= 1'b0;
      cap_fetch <= 1'b0;
    end else if (req_valid && req_ready) begin
      cap_ea    <= req_ea;
      cap_real  <= req_real;
      cap_fetch <= (req_acc == 2'b10);
    end
  end

  p_idle_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !walk_req_valid));

  p_resp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_raddr) && $stable(rsp_perm)
      && $stable(rsp_fault) && $stable(rsp_ins_code) && $stable(rsp_dsisr) && $stable(rsp_dar)));

  p_real_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && cap_real) |-> (!rsp_fault && rsp_perm == 3'b111 && rsp_raddr == cap_ea));

  p_real_nowalk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid |-> !cap_real);

  p_walk_answer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    walk_rsp_valid |-> walk_req_valid);

  p_fetch_fields_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && cap_fetch) |->
      (rsp_dsisr == 32'h0 && rsp_dar == '0 && rsp_ins_code != 32'h0));

  p_data_fields_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && !cap_fetch) |->
      (rsp_dar == cap_ea && rsp_ins_code == 32'h0 && rsp_dsisr != 32'h0));

  p_clean_success_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_ins_code == 32'h0 && rsp_dsisr == 32'h0 && rsp_dar == '0));

endmodule

bind xlt_seq xlt_seq_chk #(.EA_W(EA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_ea         (req_ea),
  .req_acc        (req_acc),
  .req_real       (req_real),
  .walk_req_valid (walk_req_valid),
  .walk_rsp_valid (walk_rsp_valid),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_fault      (rsp_fault),
  .rsp_raddr      (rsp_raddr),
  .rsp_perm       (rsp_perm),
  .rsp_ins_code   (rsp_ins_code),
  .rsp_dsisr      (rsp_dsisr),
  .rsp_dar        (rsp_dar)
);

// File: tb/xlt_seq_test.sv
`timescale 1ns/1ps
module xlt_seq_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n;
  logic         req_valid, req_ready, req_user, req_real;
  logic [31:0]  req_ea;
  logic [1:0]   req_acc;
  logic [511:0] seg_flat;
  logic         bm_hit;
  logic [1:0]   bm_pp;
  logic [31:0]  bm_raddr;
  logic         walk_req_valid, walk_rsp_valid, walk_hit;
  logic [23:0]  walk_vsid;
  logic [15:0]  walk_page;
  logic [1:0]   walk_pp;
  logic [19:0]  walk_rpn;
  logic         rsp_valid, rsp_ready, rsp_fault;
  logic [31:0]  rsp_raddr, rsp_ins_code, rsp_dsisr, rsp_dar;
  logic [2:0]   rsp_perm;

  logic [31:0] segs [16];
  always_comb for (int i = 0; i < 16; i++) seg_flat[i*32 +: 32] = segs[i];

  xlt_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ea(req_ea), .req_acc(req_acc), .req_user(req_user), .req_real(req_real),
    .seg_regs(seg_flat), .bm_hit(bm_hit), .bm_pp(bm_pp), .bm_raddr(bm_raddr),
    .walk_req_valid(walk_req_valid), .walk_vsid(walk_vsid), .walk_page(walk_page),
    .walk_rsp_valid(walk_rsp_valid), .walk_hit(walk_hit), .walk_pp(walk_pp),
    .walk_rpn(walk_rpn), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_raddr(rsp_raddr), .rsp_perm(rsp_perm),
    .rsp_ins_code(rsp_ins_code), .rsp_dsisr(rsp_dsisr), .rsp_dar(rsp_dar)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // stimulus of the current transaction
  logic        t_real, t_user, t_bm_hit, t_w_hit;
  logic [1:0]  t_acc, t_bm_pp, t_w_pp;
  logic [31:0] t_ea, t_bm_raddr;
  logic [19:0] t_w_rpn;
  int          t_wdly;

  // expected result
  logic        e_walk, e_fault;
  logic [31:0] e_raddr, e_ins, e_dsisr, e_dar;
  logic [2:0]  e_perm;
  string       e_path;

  function automatic logic allows(input logic [2:0] p, input logic [1:0] a);
    if (a == 2'b10) return p[2];
    if (a == 2'b01) return p[1];
    return p[0];
  endfunction

  task automatic model();
    logic [31:0] sr;
    logic        key;
    logic [2:0]  p;
    int          cause; // 0 ok 1 noexec 2 miss 3 prot
    sr = segs[t_ea[31:28]];
    key = t_user ? sr[29] : sr[30];
    e_walk = 1'b0; cause = 0; e_raddr = t_ea; e_perm = 3'b000;
    if (t_real) begin
      e_path = "R2"; e_perm = 3'b111;
    end else if (t_bm_hit) begin
      p = (t_bm_pp == 2'd0) ? 3'b000 : (t_bm_pp == 2'd2) ? 3'b111 : 3'b101;
      e_raddr = t_bm_raddr; e_perm = p;
      if (allows(p, t_acc)) e_path = "R3"; else begin e_path = "R4"; cause = 3; end
    end else if (sr[31]) begin
      e_path = "R6";
      if (t_acc == 2'b10) cause = 1;
      else begin
        p = key ? 3'b011 : 3'b001; e_perm = p;
        if (!allows(p, t_acc)) cause = 3;
      end
    end else if (sr[28] && t_acc == 2'b10) begin
      e_path = "R7"; cause = 1;
    end else begin
      e_walk = 1'b1;
      if (!t_w_hit) begin e_path = "R9"; cause = 2; end
      else begin
        if (!key) p = (t_w_pp == 2'd3) ? 3'b101 : 3'b111;
        else p = (t_w_pp == 2'd0) ? 3'b000 : (t_w_pp == 2'd2) ? 3'b111 : 3'b101;
        e_perm = p; e_raddr = {t_w_rpn, t_ea[11:0]};
        if (allows(p, t_acc)) e_path = "R10"; else begin e_path = "R11"; cause = 3; end
      end
    end
    e_fault = (cause != 0);
    e_ins = 0; e_dsisr = 0; e_dar = 0;
    if (e_fault) begin
      e_raddr = 0; e_perm = 0;
      if (t_acc == 2'b10) begin
        e_ins = (cause == 1) ? 32'h1000_0000 : (cause == 2) ? 32'h4000_0000 : 32'h0800_0000;
      end else begin
        e_dar = t_ea;
        if (cause == 2) e_dsisr = (t_acc == 2'b01) ? 32'h4200_0000 : 32'h4000_0000;
        else            e_dsisr = (t_acc == 2'b01) ? 32'h0A00_0000 : 32'h0800_0000;
      end
    end
  endtask

  task automatic compare_rsp(input string tag);
    check({tag, "/", e_path}, "fault", {31'd0, rsp_fault}, {31'd0, e_fault});
    check({tag, "/", e_path}, "raddr", rsp_raddr, e_raddr);
    check({tag, "/", e_path}, "perm", {29'd0, rsp_perm}, {29'd0, e_perm});
    check({tag, "/R12"}, "ins_code", rsp_ins_code, e_ins);
    check({tag, "/R12"}, "dsisr", rsp_dsisr, e_dsisr);
    check({tag, "/R12"}, "dar", rsp_dar, e_dar);
  endtask

  task automatic run_one(input string tag, input int stall);
    logic walk_seen;
    int   guard;
    model();
    @(negedge clk);
    check({tag, "/R1"}, "req_ready idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_ea = t_ea; req_acc = t_acc; req_user = t_user; req_real = t_real;
    bm_hit = t_bm_hit; bm_pp = t_bm_pp; bm_raddr = t_bm_raddr;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, "/R1"}, "req_ready busy", {31'd0, req_ready}, 32'd0);
    walk_seen = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 100) begin
      if (walk_req_valid && !walk_seen) begin
        walk_seen = 1'b1;
        check({tag, "/R5"}, "walk_vsid", {8'd0, walk_vsid}, {8'd0, segs[t_ea[31:28]][23:0]});
        check({tag, "/R5"}, "walk_page", {16'd0, walk_page}, {16'd0, t_ea[27:12]});
        for (int d = 0; d < t_wdly; d++) @(negedge clk);
        walk_rsp_valid = 1'b1; walk_hit = t_w_hit; walk_pp = t_w_pp; walk_rpn = t_w_rpn;
        @(negedge clk);
        walk_rsp_valid = 1'b0;
      end else begin
        @(negedge clk);
      end
      guard++;
    end
    check({tag, "/R5"}, "walk taken", {31'd0, walk_seen}, {31'd0, e_walk});
    check({tag, "/R1"}, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    compare_rsp(tag);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check({tag, "/R1"}, "held valid", {31'd0, rsp_valid}, 32'd1);
      check({tag, "/R1"}, "held raddr", rsp_raddr, e_raddr);
      check({tag, "/R1"}, "held dsisr", rsp_dsisr, e_dsisr);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check({tag, "/R1"}, "rsp_valid drop", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic setreq(input logic rl, input logic [1:0] acc, input logic usr, input logic [31:0] ea,
                        input logic bh, input logic [1:0] bpp, input logic [31:0] sr,
                        input logic wh, input logic [1:0] wpp);
    t_real = rl; t_acc = acc; t_user = usr; t_ea = ea; t_bm_hit = bh; t_bm_pp = bpp;
    t_bm_raddr = 32'hB000_0000 | (ea & 32'h0FFF_FFFF);
    segs[ea[31:28]] = sr;
    t_w_hit = wh; t_w_pp = wpp; t_w_rpn = 20'h5A5A5; t_wdly = 1;
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 0; req_ea = 0; req_acc = 0; req_user = 0; req_real = 0;
    bm_hit = 0; bm_pp = 0; bm_raddr = 0; walk_rsp_valid = 0; walk_hit = 0; walk_pp = 0;
    walk_rpn = 0; rsp_ready = 0;
    for (int i = 0; i < 16; i++) segs[i] = 32'h0000_1000 + i;
    repeat (3) @(negedge clk);
    check("R1", "reset req_ready", {31'd0, req_ready}, 32'd1);
    check("R1", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R5", "reset walk_req", {31'd0, walk_req_valid}, 32'd0);
    check("R12", "reset fault", {31'd0, rsp_fault}, 32'd0);
    rst_n = 1'b1;

    // R2: real mode ignores a block hit and a direct-store segment
    setreq(1, 2'b10, 0, 32'h3123_4567, 1, 2'd0, 32'h8000_0000, 0, 0); run_one("R2", 0);
    // R3: block hit wins over a direct-store segment, store with pp 2
    setreq(0, 2'b01, 0, 32'h4000_0ABC, 1, 2'd2, 32'h8000_0000, 0, 0); run_one("R3", 2);
    // R3: pp 3 allows fetch
    setreq(0, 2'b10, 1, 32'h4111_0ABC, 1, 2'd3, 32'h0000_0022, 0, 0); run_one("R3", 0);
    // R4: pp 0 load, pp 1 store, pp 1 fetch allowed? (read+exec yes) -> pp 0 fetch
    setreq(0, 2'b00, 0, 32'h5000_0010, 1, 2'd0, 32'h0000_0001, 0, 0); run_one("R4", 0);
    setreq(0, 2'b01, 0, 32'h5000_0020, 1, 2'd1, 32'h0000_0001, 0, 0); run_one("R4", 1);
    setreq(0, 2'b10, 0, 32'h5000_0030, 1, 2'd0, 32'h0000_0001, 0, 0); run_one("R4", 0);
    // R6: direct store
    setreq(0, 2'b10, 0, 32'h6000_0040, 0, 2'd0, 32'hC000_0000, 0, 0); run_one("R6", 0);
    setreq(0, 2'b01, 0, 32'h6000_0050, 0, 2'd0, 32'h8000_0000, 0, 0); run_one("R6", 0);
    setreq(0, 2'b01, 0, 32'h6000_0060, 0, 2'd0, 32'hC000_0000, 0, 0); run_one("R6", 0);
    setreq(0, 2'b00, 0, 32'h6000_0070, 0, 2'd0, 32'h8000_0000, 0, 0); run_one("R6", 0);
    // R7: no-execute fetch faults, load walks
    setreq(0, 2'b10, 0, 32'h7000_1000, 0, 2'd0, 32'h1000_0777, 1, 2'd2); run_one("R7", 0);
    setreq(0, 2'b00, 0, 32'h7000_2000, 0, 2'd0, 32'h1000_0777, 1, 2'd2); run_one("R7", 0);
    // R8: same segment, user key 1 vs supervisor key 0, store to pp 1
    setreq(0, 2'b01, 1, 32'h8000_3004, 0, 2'd0, 32'h2012_3456, 1, 2'd1); run_one("R8", 0);
    setreq(0, 2'b01, 0, 32'h8000_3004, 0, 2'd0, 32'h2012_3456, 1, 2'd1); run_one("R8", 0);
    // R9: misses for each access kind
    setreq(0, 2'b10, 0, 32'h9ABC_D123, 0, 2'd0, 32'h00AB_CDEF, 0, 0); run_one("R9", 0);
    setreq(0, 2'b00, 0, 32'h9ABC_D124, 0, 2'd0, 32'h00AB_CDEF, 0, 0); run_one("R9", 0);
    setreq(0, 2'b01, 0, 32'h9ABC_D125, 0, 2'd0, 32'h00AB_CDEF, 0, 0); run_one("R9", 1);
    // R10 / R11: key 0 pp 3 store denied, key 1 pp 0 load denied, key 1 pp 2 store ok
    setreq(0, 2'b01, 0, 32'hA000_4008, 0, 2'd0, 32'h0000_0100, 1, 2'd3); run_one("R11", 0);
    setreq(0, 2'b00, 0, 32'hA000_5008, 0, 2'd0, 32'h4000_0100, 1, 2'd0); run_one("R11", 0);
    setreq(0, 2'b01, 0, 32'hA000_6008, 0, 2'd0, 32'h4000_0100, 1, 2'd2); run_one("R10", 0);
    setreq(0, 2'b11, 1, 32'hA000_7008, 0, 2'd0, 32'h2000_0100, 1, 2'd1); run_one("R10", 0);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      t_real   = ($urandom % 10) == 0;
      t_acc    = 2'($urandom % 4);
      t_user   = 1'($urandom);
      t_ea     = $urandom;
      t_bm_hit = ($urandom % 4) == 0;
      t_bm_pp  = 2'($urandom);
      t_bm_raddr = $urandom;
      begin
        logic [31:0] sr;
        sr = $urandom & 32'h60FF_FFFF;
        if (($urandom % 5) == 0) sr[31] = 1'b1;
        if (($urandom % 3) == 0) sr[28] = 1'b1;
        segs[t_ea[31:28]] = sr;
      end
      t_w_hit = ($urandom % 4) != 0;
      t_w_pp  = 2'($urandom);
      t_w_rpn = 20'($urandom);
      t_wdly  = $urandom % 4;
      run_one("RND", $urandom % 3);
    end

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule